// File: doc/BRIEF.md
# CEC Line Receiver with Acknowledge

This block listens on a shared open-drain consumer-electronics-control line. It finds a start bit of valid length and then reads data bits in ten-bit slots. Each slot holds eight data bits, sent most significant first, then an end-of-message flag, then an acknowledge position. A microsecond tick input drives all timing, and every window is a parameter given in microseconds.

The receiver drives the line only through a pull-down enable. It pulls the line low for two reasons. The first is to acknowledge a directed frame whose destination is set in the 16-bit address mask. The second is to signal an error when a bit period is too short. When a byte carrying the end-of-message flag has passed its acknowledge slot, the block copies the assembled bytes and their count to its outputs and raises a one-cycle valid strobe.

The line input passes through a two-flop synchronizer before the falling-edge detector.

Top module: `cec_rx_ack`

## Requirements
- R1: A start bit whose low phase lasts less than START_LOW_MIN_US (3500) is dropped. The block returns to idle with no acknowledge, no error pulse and no message.
- R2: If no falling edge follows within START_TOTAL_MAX_US (4700) of the start bit's falling edge, the frame is dropped to idle.
- R3: Each bit is sampled SAMPLE_US (850) after its falling edge. Slot positions 0..7 form the byte MSB first, and byte k of the message appears at msg_o[8k+7:8k]. Position 8 is the end-of-message flag (1 = last byte), and position 9 is the acknowledge slot.
- R4: A falling edge less than BIT_MIN_US (2050) after the previous bit's falling edge makes the block hold pull_low_o for ERR_LOW_US (3600). It then returns to idle and delivers no message.
- R5: If the line stays high more than BIT_MAX_US (2750) after a bit's falling edge, the frame is dropped with no message.
- R6: The destination is bits [3:0] of the first byte. If it is not 15 and its bit in addr_mask_i is 1, pull_low_o is held for ACK_LOW_US (1500) from the falling edge of every acknowledge slot of the frame.
- R7: Frames with destination 15 (broadcast), and frames whose destination bit in the mask is 0, are never driven, even when mask bit 15 is set.
- R8: After the acknowledge slot of a byte whose end-of-message flag is 1, msg_valid_o pulses for one cycle with msg_len_o equal to that byte's index plus one. The block returns to idle BIT_MIN_US after that slot's falling edge.
- R9: At most MAX_BYTES (16) bytes are stored. Later bytes are still timed and acknowledged, and msg_len_o saturates at MAX_BYTES.
- R10: The receive buffer is cleared at each start bit, so unused bytes read as zero. msg_o and msg_len_o change only together with msg_valid_o.
- R11: After reset, pull_low_o and msg_valid_o are 0 and msg_len_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_us_i | input | 1 | One-cycle pulse per microsecond |
| line_i | input | 1 | Line level (1 = released) |
| addr_mask_i | input | 16 | One bit per logical address this device answers |
| pull_low_o | output | 1 | Open-drain pull-down enable |
| msg_o | output | MAX_BYTES*8 | Last delivered message, byte 0 in bits [7:0] |
| msg_len_o | output | $clog2(MAX_BYTES+1) | Byte count of the last delivered message |
| msg_valid_o | output | 1 | One-cycle strobe for a new message |

## Verification
Several properties are checked every cycle. The error pulse must last for its whole window. An acknowledge may start only when the stored destination is directed and set in the mask. The valid strobe must be a single cycle and must follow an end-of-message byte. The message outputs must hold between deliveries. A short start low must return the block to idle. Only the bench scenarios show the timing at the wire: pulse lengths, dropped frames with too-long highs, MSB-first byte assembly, overflow past sixteen bytes, and the zeroing of unused bytes when a shorter message follows a longer one.

// File: rtl/cec_rx_pkg.sv
package cec_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLOW,   // start bit, low phase
    ST_SHIGH,  // start bit, high phase
    ST_BIT,    // data, eom or ack slot in progress
    ST_ACK,    // driving acknowledge
    ST_ERR,    // driving error low
    ST_DONE    // message delivered, waiting for end of bit
  } rx_state_e;
endpackage

// File: rtl/cec_line_sync.sv
module cec_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic level_o,
  output logic fall_o
);
  logic [2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= 3'b111;
    else         sh_q <= {sh_q[1:0], line_i};
  end

  assign level_o = sh_q[1];
  assign fall_o  = sh_q[2] & ~sh_q[1];
endmodule

// File: rtl/cec_us_timer.sv
module cec_us_timer #(
  parameter int unsigned W = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_o <= '0;
    else if (clr_i)                 cnt_o <= '0;
    else if (tick_i && ~&cnt_o)     cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/cec_rx_buf.sv
module cec_rx_buf #(
  parameter int unsigned MAX_BYTES = 16,
  localparam int unsigned IDX_W = $clog2(MAX_BYTES),
  localparam int unsigned LEN_W = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   wr_i,
  input  logic [IDX_W-1:0]       wr_byte_i,
  input  logic [2:0]             wr_bit_i,
  input  logic                   wr_val_i,
  input  logic                   deliver_i,
  input  logic [LEN_W-1:0]       len_i,
  output logic [3:0]             dest_o,
  output logic [MAX_BYTES*8-1:0] msg_o,
  output logic [LEN_W-1:0]       len_o,
  output logic                   valid_o
);
  logic [MAX_BYTES*8-1:0] work_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      work_q <= '0;
    else if (clr_i)   work_q <= '0;
    else if (wr_i)    work_q[{wr_byte_i, wr_bit_i}] <= wr_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_o   <= '0;
      len_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= deliver_i;
      if (deliver_i) begin
        msg_o <= work_q;
        len_o <= len_i;
      end
    end
  end

  assign dest_o = work_q[3:0];

  AST_HOLD_MSG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !deliver_i |=> $stable(msg_o) && $stable(len_o)); // R10
  AST_LEN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (len_o != '0) && (len_o <= LEN_W'(MAX_BYTES))); // R9
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R8
endmodule

// File: rtl/cec_rx_ack.sv
module cec_rx_ack
  import cec_rx_pkg::*;
#(
  parameter int unsigned MAX_BYTES          = 16,
  parameter int unsigned START_LOW_MIN_US   = 3500,
  parameter int unsigned START_TOTAL_MAX_US = 4700,
  parameter int unsigned SAMPLE_US          = 850,
  parameter int unsigned BIT_MIN_US         = 2050,
  parameter int unsigned BIT_MAX_US         = 2750,
  parameter int unsigned ACK_LOW_US         = 1500,
  parameter int unsigned ACK_END_US         = 1750,
  parameter int unsigned ERR_LOW_US         = 3600
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           tick_us_i,
  input  logic                           line_i,
  input  logic [15:0]                    addr_mask_i,
  output logic                           pull_low_o,
  output logic [MAX_BYTES*8-1:0]         msg_o,
  output logic [$clog2(MAX_BYTES+1)-1:0] msg_len_o,
  output logic                           msg_valid_o
);
  localparam int unsigned IDX_W = $clog2(MAX_BYTES);
  localparam int unsigned LEN_W = $clog2(MAX_BYTES + 1);
  localparam int unsigned CNT_W = $clog2(ERR_LOW_US + START_TOTAL_MAX_US + BIT_MAX_US + 1);
  localparam logic [CNT_W-1:0] L_SLOW   = CNT_W'(START_LOW_MIN_US);
  localparam logic [CNT_W-1:0] L_STOT   = CNT_W'(START_TOTAL_MAX_US);
  localparam logic [CNT_W-1:0] L_SAMPLE = CNT_W'(SAMPLE_US);
  localparam logic [CNT_W-1:0] L_BMIN   = CNT_W'(BIT_MIN_US);
  localparam logic [CNT_W-1:0] L_BMAX   = CNT_W'(BIT_MAX_US);
  localparam logic [CNT_W-1:0] L_ACK    = CNT_W'(ACK_LOW_US);
  localparam logic [CNT_W-1:0] L_AEND   = CNT_W'(ACK_END_US);
  localparam logic [CNT_W-1:0] L_ERR    = CNT_W'(ERR_LOW_US);
  localparam logic [LEN_W-1:0] L_MAXB   = LEN_W'(MAX_BYTES);

  rx_state_e        state_q, state_d;
  logic             line_lvl, line_fall;
  logic [CNT_W-1:0] cnt;
  logic             cnt_clr, frame_go, bit_go, smp_en, deliver, pull_d, pull_q;
  logic [3:0]       slot_q;
  logic [LEN_W-1:0] byte_q;
  logic             eom_q, sampled_q;
  logic [3:0]       dest;
  logic             ack_hit, wr_en;
  logic [LEN_W-1:0] len_now;

  cec_line_sync i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .level_o(line_lvl),
    .fall_o (line_fall)
  );

  cec_us_timer #(.W(CNT_W)) i_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_us_i),
    .clr_i (cnt_clr),
    .cnt_o (cnt)
  );

  assign ack_hit = (dest != 4'hF) && addr_mask_i[dest];
  assign len_now = (byte_q == L_MAXB) ? L_MAXB : byte_q + 1'b1;
  assign wr_en   = smp_en && (slot_q < 4'd8) && (byte_q < L_MAXB);

  cec_rx_buf #(.MAX_BYTES(MAX_BYTES)) i_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (state_q == ST_IDLE && line_fall),
    .wr_i     (wr_en),
    .wr_byte_i(byte_q[IDX_W-1:0]),
    .wr_bit_i (~slot_q[2:0]),
    .wr_val_i (line_lvl),
    .deliver_i(deliver),
    .len_i    (len_now),
    .dest_o   (dest),
    .msg_o    (msg_o),
    .len_o    (msg_len_o),
    .valid_o  (msg_valid_o)
  );

  always_comb begin
    state_d  = state_q;
    cnt_clr  = 1'b0;
    frame_go = 1'b0;
    bit_go   = 1'b0;
    smp_en   = 1'b0;
    deliver  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (line_fall) begin
        state_d = ST_SLOW;
        cnt_clr = 1'b1;
      end
      ST_SLOW: if (line_lvl) state_d = (cnt < L_SLOW) ? ST_IDLE : ST_SHIGH;
      ST_SHIGH: begin
        if (line_fall) begin
          state_d  = ST_BIT;
          cnt_clr  = 1'b1;
          frame_go = 1'b1;
        end else if (cnt > L_STOT) begin
          state_d = ST_IDLE;
        end
      end
      ST_BIT: begin
        if (line_fall) begin
          cnt_clr = 1'b1;
          if (cnt < L_BMIN) begin
            state_d = ST_ERR;
          end else begin
            bit_go = 1'b1;
            if (slot_q == 4'd8 && ack_hit) state_d = ST_ACK;
          end
        end else if (!sampled_q && cnt >= L_SAMPLE) begin
          smp_en = 1'b1;
        end else if (slot_q == 4'd9 && eom_q && cnt >= L_AEND) begin
          deliver = 1'b1;
          state_d = ST_DONE;
        end else if (line_lvl && cnt > L_BMAX) begin
          state_d = ST_IDLE;
        end
      end
      ST_ACK:  if (cnt >= L_ACK)  state_d = ST_BIT;
      ST_ERR:  if (cnt >= L_ERR)  state_d = ST_IDLE;
      ST_DONE: if (cnt >= L_BMIN) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign pull_d     = (state_d == ST_ACK) || (state_d == ST_ERR);
  assign pull_low_o = pull_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      pull_q    <= 1'b0;
      slot_q    <= '0;
      byte_q    <= '0;
      eom_q     <= 1'b0;
      sampled_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pull_q  <= pull_d;
      if (frame_go) begin
        slot_q    <= '0;
        byte_q    <= '0;
        eom_q     <= 1'b0;
        sampled_q <= 1'b0;
      end else if (bit_go) begin
        sampled_q <= 1'b0;
        if (slot_q == 4'd9) begin
          slot_q <= '0;
          if (byte_q != L_MAXB) byte_q <= byte_q + 1'b1;
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end else if (smp_en) begin
        sampled_q <= 1'b1;
        if (slot_q == 4'd8) eom_q <= line_lvl;
      end
    end
  end

  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ERR && cnt < L_ERR) |=> pull_low_o); // R4
  AST_ACK_DIRECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pull_low_o) && state_q == ST_ACK) |-> (dest != 4'hF) && addr_mask_i[dest]); // R7
  AST_VALID_EOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> eom_q && state_q == ST_DONE); // R8
  AST_SHORT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLOW && line_lvl && cnt < L_SLOW) |=> state_q == ST_IDLE); // R1
endmodule

// File: tb/test_cec_rx_ack.sv
module test_cec_rx_ack;
  localparam int MAXB = 16;
  localparam int T1   = 60;   // low time of a '1' bit (scaled us)
  localparam int T0   = 150;  // low time of a '0' bit
  localparam int TBIT = 240;
  localparam int ACKL = 150;
  localparam int ERRL = 360;

  typedef struct {
    int                  len;
    logic [MAXB*8-1:0]   data;
  } exp_msg_t;

  logic clk = 1'b0, rst_n = 1'b0, tb_low = 1'b0;
  logic [15:0] mask = 16'h8014;  // addresses 2, 4 and 15
  logic pull, valid, line;
  logic [MAXB*8-1:0] msg;
  logic [4:0] len;
  int checks = 0, errors = 0, n_valid = 0, n_pulse = 0, plen = 0;
  exp_msg_t exp_msgs[$];
  int exp_pulses[$];
  logic [7:0] fb [0:31];

  assign line = !(tb_low || pull);
  always #5 clk = ~clk;

  cec_rx_ack #(
    .MAX_BYTES(MAXB), .START_LOW_MIN_US(350), .START_TOTAL_MAX_US(470),
    .SAMPLE_US(85), .BIT_MIN_US(205), .BIT_MAX_US(275),
    .ACK_LOW_US(ACKL), .ACK_END_US(175), .ERR_LOW_US(ERRL)
  ) i_cec_rx_ack (
    .clk_i(clk), .rst_ni(rst_n), .tick_us_i(1'b1), .line_i(line),
    .addr_mask_i(mask), .pull_low_o(pull), .msg_o(msg),
    .msg_len_o(len), .msg_valid_o(valid)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scoreboard: messages
  always @(negedge clk) begin : mon_msg
    exp_msg_t e;
    if (rst_n && valid) begin
      n_valid++;
      checks++;
      if (exp_msgs.size() == 0) begin
        errors++;
        $display("FAIL R8: unexpected message len %0d, expected none", len);
      end else begin
        e = exp_msgs.pop_front();
        if (int'(len) != e.len || msg !== e.data) begin
          errors++;
          $display("FAIL R3/R9/R10: actual len %0d data %h expected len %0d data %h",
                   len, msg, e.len, e.data);
        end
      end
    end
  end

  // scoreboard: pull-down pulses
  always @(negedge clk) begin : mon_pull
    int ex;
    if (rst_n) begin
      if (pull) plen++;
      else if (plen != 0) begin
        n_pulse++;
        checks++;
        if (exp_pulses.size() == 0) begin
          errors++;
          $display("FAIL R7: pull pulse of %0d cycles, expected none", plen);
        end else begin
          ex = exp_pulses.pop_front();
          if (plen < ex - 3 || plen > ex + 3) begin
            errors++;
            $display("FAIL R4/R6: pulse length actual %0d expected %0d", plen, ex);
          end
        end
        plen = 0;
      end
    end
  end

  task automatic hold(input bit low, input int n);
    tb_low = low;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input bit v);
    hold(1'b1, v ? T1 : T0);
    hold(1'b0, TBIT - (v ? T1 : T0));
  endtask

  task automatic send_start();
    hold(1'b1, 370);
    hold(1'b0, 80);
  endtask

  task automatic send_frame(input int n);
    exp_msg_t e;
    logic [3:0] d;
    bit acked;
    d = fb[0][3:0];
    acked = (d != 4'hF) && mask[d];
    e.len = (n > MAXB) ? MAXB : n;
    e.data = '0;
    for (int i = 0; i < n; i++) begin
      if (i < MAXB) e.data[i*8 +: 8] = fb[i];
      if (acked) exp_pulses.push_back(ACKL);
    end
    exp_msgs.push_back(e);
    send_start();
    for (int i = 0; i < n; i++) begin
      for (int k = 7; k >= 0; k--) send_bit(fb[i][k]);
      send_bit(i == n - 1);
      send_bit(1'b1);
    end
    hold(1'b0, 400);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R8: watchdog expired, actual running expected finished");
    finish_run();
  end

  initial begin
    logic [MAXB*8-1:0] m0;
    int nv, np;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(pull == 1'b0,  "R11 pull", pull, 0);
    check(valid == 1'b0, "R11 valid", valid, 0);
    check(len == 5'd0,   "R11 len", len, 0);

    // directed to address 4, three bytes
    fb[0] = 8'h34; fb[1] = 8'hA5; fb[2] = 8'h0F;
    send_frame(3);
    check(n_valid == 1, "R8 message count", n_valid, 1);
    check(n_pulse == 3, "R6 ack count", n_pulse, 3);

    // broadcast, two bytes; byte 2 must read zero
    fb[0] = 8'h3F; fb[1] = 8'h82;
    send_frame(2);
    check(n_pulse == 3, "R7 broadcast not acked", n_pulse, 3);

    // other device (address 5)
    fb[0] = 8'h35; fb[1] = 8'h11;
    send_frame(2);
    check(n_pulse == 3, "R7 foreign not acked", n_pulse, 3);
    check(n_valid == 3, "R8 message count", n_valid, 3);

    m0 = msg; nv = n_valid; np = n_pulse;
    hold(1'b1, 200); hold(1'b0, 600);
    check(n_valid == nv && n_pulse == np, "R1 short start ignored", n_valid + n_pulse, nv + np);
    check(msg === m0, "R10 outputs held", 0, 0);

    hold(1'b1, 370); hold(1'b0, 600);
    check(n_valid == nv && n_pulse == np, "R2 long start dropped", n_valid + n_pulse, nv + np);

    send_start();
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    hold(1'b0, 600);
    check(n_valid == nv && n_pulse == np, "R5 long high dropped", n_valid + n_pulse, nv + np);

    exp_pulses.push_back(ERRL);
    send_start();
    hold(1'b1, 60); hold(1'b0, 80);
    hold(1'b1, 60); hold(1'b0, 700);
    check(n_pulse == np + 1, "R4 error pulse seen", n_pulse, np + 1);
    check(n_valid == nv, "R4 no message", n_valid, nv);

    // recovery, one byte to address 2
    fb[0] = 8'h12;
    send_frame(1);
    check(n_valid == nv + 1, "R8 recovery message", n_valid, nv + 1);
    check(len == 5'd1, "R8 length one", len, 1);

    // overflow: 18 bytes to address 4
    fb[0] = 8'h04;
    for (int i = 1; i < 18; i++) fb[i] = 8'(i * 9 + 3);
    np = n_pulse;
    send_frame(18);
    check(len == 5'd16, "R9 length saturates", len, 16);
    check(n_pulse == np + 18, "R9 extra bytes acked", n_pulse, np + 18);

    repeat (20) @(negedge clk);
    check(exp_msgs.size() == 0, "R8 pending messages", exp_msgs.size(), 0);
    check(exp_pulses.size() == 0, "R6 pending pulses", exp_pulses.size(), 0);
    finish_run();
  end
endmodule